// File: doc/BRIEF.md
# Power-Up Protocol Selector with Answer-to-Reset

This block decides, once per power cycle, which serial protocol a secure-memory front end will speak, judging only from how the reset pin behaves right after power-on reset is released. A reset pin already high at the first clock edge (its unbonded, pulled-up state) selects the synchronous two-wire protocol. A reset pin held low while the clock runs, then raised after a long enough cold-reset interval, selects the asynchronous smart-card protocol. The choice then holds until power-on reset is applied again.

In asynchronous mode the block sends a programmable 8-byte answer-to-reset on an open-drain data output, one character frame per byte, with every bit lasting one elementary time unit of 372 clock periods. In synchronous mode it sends nothing and only counts a short warm-up before it tells the command layer that commands may start. Command decoding for both protocols sits outside this block. The answer-to-reset leaves as a timed line waveform with no handshake, so every pin here is a plain control or status pin.

Top module: `proto_boot_sel`

## Requirements
- R1: While power-on reset is active, and after its release until a mode is chosen, mode_locked, mode_async, cmd_ready and io_pull_low are all 0.
- R2: If rst_pin is high at the first clock edge after power-on reset is released, synchronous mode is chosen at that edge (mode_locked=1, mode_async=0).
- R3: If rst_pin is low at that first edge, the block counts the clock edges at which rst_pin is sampled low. At the first edge where rst_pin is sampled high, asynchronous mode is chosen if the count is at least 400 (mode_async=1); otherwise synchronous mode is chosen.
- R4: In synchronous mode cmd_ready stays 0 for the first four clock edges after the selection edge and becomes 1 at the fifth.
- R5: Once chosen, mode_locked and mode_async do not change until power-on reset. In synchronous mode rst_pin has no effect at all: cmd_ready stays 1 and io_pull_low stays 0.
- R6: In asynchronous mode the answer-to-reset starts at the selection edge. It sends the bytes of atr_word in order, byte 0 = atr_word[7:0] first, and each bit cell lasts 372 clock periods.
- R7: Each byte is a 12-cell frame: a start cell at level 0, eight data cells LSB first, a parity cell that makes the count of ones in data plus parity even, and two guard cells at level 1.
- R8: The output is open drain: io_pull_low=1 drives the line to 0. A level-1 cell, a line with no transmission and all of synchronous mode give io_pull_low=0.
- R9: In asynchronous mode cmd_ready becomes 1 at the edge that ends the last guard cell, 96 cells after the selection edge, and is 0 throughout the transmission.
- R10: In asynchronous mode, rst_pin sampled low at an edge stops any transmission at that edge and clears cmd_ready, while the mode is kept. The next edge that samples rst_pin high restarts the answer-to-reset from byte 0 with the R6 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock; all state advances on its rising edge |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_pin | input | 1 | Reset pin level, synchronous to clk; reads 1 when unbonded |
| atr_word | input | 64 | Answer-to-reset contents, byte 0 in bits 7:0 |
| mode_locked | output | 1 | 1 once a protocol has been chosen |
| mode_async | output | 1 | 1 when the asynchronous protocol is chosen |
| io_pull_low | output | 1 | 1 pulls the open-drain data line low |
| cmd_ready | output | 1 | Command layer may start accepting commands |

## Verification
Mode outputs are due right after the edge that samples the deciding rst_pin level: the first edge after reset release, or the edge where rst_pin is first seen high after the low interval. The bench drives rst_pin on the falling edge and reads the outputs on the next falling edge. Synchronous readiness is due five edges later, and the bench reads cmd_ready after each of those five edges. Answer-to-reset cell k occupies edges S+372k through S+372(k+1)-1 after the selection edge S. The bench reads each cell in its middle, 186 edges into it, and reads cmd_ready again just after edge S+96*372. Abort and restart effects are due one edge after the rst_pin change and are read at the falling edge that follows.

// File: rtl/proto_boot_pkg.sv
package proto_boot_pkg;

  typedef enum logic [2:0] {
    PB_SAMPLE,
    PB_COLD,
    PB_WARM,
    PB_SYNC_RDY,
    PB_ATR,
    PB_ASYNC_RDY,
    PB_HOLD
  } pb_state_e;

  localparam int unsigned FRAME_CELLS = 12;

  function automatic logic even_fill(input logic [7:0] data);
    return ^data;
  endfunction

endpackage

// File: rtl/proto_boot_fsm.sv
module proto_boot_fsm
  import proto_boot_pkg::*;
#(
  parameter int unsigned COLD_MIN_CLKS = 400,
  parameter int unsigned WARM_CLKS     = 5
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  input  logic atr_done,
  output logic atr_start,
  output logic atr_abort,
  output logic mode_locked,
  output logic mode_async,
  output logic cmd_ready
);

  localparam int unsigned CW = $clog2(COLD_MIN_CLKS + 1);
  localparam int unsigned WW = $clog2(WARM_CLKS + 1);
  localparam logic [CW-1:0] COLD_LIM  = CW'(COLD_MIN_CLKS);
  localparam logic [WW-1:0] WARM_LAST = WW'(WARM_CLKS - 1);

  pb_state_e       state, nxt;
  logic [CW-1:0]   low_cnt;
  logic [WW-1:0]   warm_cnt;

  always_comb begin
    nxt       = state;
    atr_start = 1'b0;
    atr_abort = 1'b0;
    case (state)
      PB_SAMPLE: nxt = rst_pin ? PB_WARM : PB_COLD;
      PB_COLD: begin
        if (rst_pin) begin
          if (low_cnt >= COLD_LIM) begin
            nxt       = PB_ATR;
            atr_start = 1'b1;
          end else begin
            nxt = PB_WARM;
          end
        end
      end
      PB_WARM: if (warm_cnt == WARM_LAST) nxt = PB_SYNC_RDY;
      PB_SYNC_RDY: nxt = PB_SYNC_RDY;
      PB_ATR: begin
        if (!rst_pin) begin
          nxt       = PB_HOLD;
          atr_abort = 1'b1;
        end else if (atr_done) begin
          nxt = PB_ASYNC_RDY;
        end
      end
      PB_ASYNC_RDY: if (!rst_pin) nxt = PB_HOLD;
      PB_HOLD: begin
        if (rst_pin) begin
          nxt       = PB_ATR;
          atr_start = 1'b1;
        end
      end
      default: nxt = PB_SAMPLE;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state    <= PB_SAMPLE;
      low_cnt  <= '0;
      warm_cnt <= '0;
    end else begin
      state <= nxt;
      if ((state == PB_SAMPLE || state == PB_COLD) && !rst_pin && low_cnt != COLD_LIM)
        low_cnt <= low_cnt + 1'b1;
      if (state == PB_WARM)
        warm_cnt <= warm_cnt + 1'b1;
      else
        warm_cnt <= '0;
    end
  end

  assign mode_locked = (state != PB_SAMPLE) && (state != PB_COLD);
  assign mode_async  = (state == PB_ATR) || (state == PB_ASYNC_RDY) || (state == PB_HOLD);
  assign cmd_ready   = (state == PB_SYNC_RDY) || (state == PB_ASYNC_RDY);

endmodule

// File: rtl/proto_boot_atr_tx.sv
module proto_boot_atr_tx
  import proto_boot_pkg::*;
#(
  parameter int unsigned ETU_CLKS  = 372,
  parameter int unsigned ATR_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   start,
  input  logic                   abort,
  input  logic [8*ATR_BYTES-1:0] atr_word,
  output logic                   pull_low,
  output logic                   done
);

  localparam int unsigned EW  = (ETU_CLKS > 1) ? $clog2(ETU_CLKS) : 1;
  localparam int unsigned BYW = (ATR_BYTES > 1) ? $clog2(ATR_BYTES) : 1;
  localparam logic [EW-1:0]  ETU_LAST  = EW'(ETU_CLKS - 1);
  localparam logic [BYW-1:0] BYTE_LAST = BYW'(ATR_BYTES - 1);
  localparam logic [3:0]     CELL_LAST = 4'(FRAME_CELLS - 1);

  logic [7:0]     atr_bytes [ATR_BYTES];
  logic           busy;
  logic [EW-1:0]  etu_cnt;
  logic [3:0]     cell_idx;
  logic [BYW-1:0] byte_idx;
  logic [7:0]     cur_byte;
  logic [2:0]     data_sel;
  logic           cell_end, frame_end, line_level;

  for (genvar g = 0; g < ATR_BYTES; g++) begin : g_bytes
    assign atr_bytes[g] = atr_word[g*8 +: 8];
  end

  assign cur_byte  = atr_bytes[byte_idx];
  assign cell_end  = busy && (etu_cnt == ETU_LAST);
  assign frame_end = cell_end && (cell_idx == CELL_LAST);
  assign done      = frame_end && (byte_idx == BYTE_LAST);
  assign data_sel  = 3'(cell_idx - 4'd1);

  always_comb begin
    case (cell_idx)
      4'd0:                                       line_level = 1'b0;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8: line_level = cur_byte[data_sel];
      4'd9:                                       line_level = even_fill(cur_byte);
      default:                                    line_level = 1'b1;
    endcase
  end

  assign pull_low = busy && !line_level;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy     <= 1'b0;
      etu_cnt  <= '0;
      cell_idx <= '0;
      byte_idx <= '0;
    end else if (start || abort) begin
      busy     <= start;
      etu_cnt  <= '0;
      cell_idx <= '0;
      byte_idx <= '0;
    end else if (cell_end) begin
      etu_cnt <= '0;
      if (frame_end) begin
        cell_idx <= '0;
        if (done) busy <= 1'b0;
        else      byte_idx <= byte_idx + 1'b1;
      end else begin
        cell_idx <= cell_idx + 1'b1;
      end
    end else if (busy) begin
      etu_cnt <= etu_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/proto_boot_sel.sv
module proto_boot_sel #(
  parameter int unsigned ETU_CLKS      = 372,
  parameter int unsigned COLD_MIN_CLKS = 400,
  parameter int unsigned WARM_CLKS     = 5,
  parameter int unsigned ATR_BYTES     = 8
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   rst_pin,
  input  logic [8*ATR_BYTES-1:0] atr_word,
  output logic                   mode_locked,
  output logic                   mode_async,
  output logic                   io_pull_low,
  output logic                   cmd_ready
);

  logic atr_start, atr_abort, atr_done;

  proto_boot_fsm #(
    .COLD_MIN_CLKS(COLD_MIN_CLKS),
    .WARM_CLKS    (WARM_CLKS)
  ) u_fsm (
    .clk        (clk),
    .por_n      (por_n),
    .rst_pin    (rst_pin),
    .atr_done   (atr_done),
    .atr_start  (atr_start),
    .atr_abort  (atr_abort),
    .mode_locked(mode_locked),
    .mode_async (mode_async),
    .cmd_ready  (cmd_ready)
  );

  proto_boot_atr_tx #(
    .ETU_CLKS (ETU_CLKS),
    .ATR_BYTES(ATR_BYTES)
  ) u_tx (
    .clk     (clk),
    .por_n   (por_n),
    .start   (atr_start),
    .abort   (atr_abort),
    .atr_word(atr_word),
    .pull_low(io_pull_low),
    .done    (atr_done)
  );

endmodule

// File: rtl/proto_boot_sel_chk.sv
module proto_boot_sel_chk (
  input logic clk,
  input logic por_n,
  input logic rst_pin,
  input logic mode_locked,
  input logic mode_async,
  input logic io_pull_low,
  input logic cmd_ready
);

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    mode_locked |=> mode_locked && $stable(mode_async));

  // R1
  async_needs_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
    mode_async |-> mode_locked);

  // R8
  sync_line_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    !mode_async |-> !io_pull_low);

  // R9
  ready_line_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    cmd_ready |-> !io_pull_low);

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    (mode_async && !rst_pin) |=> !cmd_ready && !io_pull_low && mode_async);

  // R4
  warm_not_instant_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mode_locked) |-> !cmd_ready);

  // R5
  sync_ready_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (mode_locked && !mode_async && cmd_ready) |=> cmd_ready);

endmodule

bind proto_boot_sel proto_boot_sel_chk u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_pin    (rst_pin),
  .mode_locked(mode_locked),
  .mode_async (mode_async),
  .io_pull_low(io_pull_low),
  .cmd_ready  (cmd_ready)
);

// File: tb/proto_boot_sel_bench.sv
`timescale 1ns/1ps
module proto_boot_sel_bench;

  localparam int ETU  = 372;
  localparam int COLD = 400;
  localparam int WARM = 5;
  localparam int CELLS = 96;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_pin = 1'b1;
  logic [63:0] atr_word = '0;
  logic        mode_locked, mode_async, io_pull_low, cmd_ready;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  proto_boot_sel u_proto_boot_sel (
    .clk        (clk),
    .por_n      (por_n),
    .rst_pin    (rst_pin),
    .atr_word   (atr_word),
    .mode_locked(mode_locked),
    .mode_async (mode_async),
    .io_pull_low(io_pull_low),
    .cmd_ready  (cmd_ready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // expected io_pull_low for cell k of the answer-to-reset
  function automatic logic exp_pull(input logic [63:0] w, input int k);
    int   byt = k / 12;
    int   pos = k % 12;
    logic [7:0] b = w[byt*8 +: 8];
    logic lvl;
    if (pos == 0)      lvl = 1'b0;
    else if (pos <= 8) lvl = b[pos-1];
    else if (pos == 9) lvl = ^b;
    else               lvl = 1'b1;
    return !lvl;
  endfunction

  task automatic power_up(input logic lvl);
    por_n   = 1'b0;
    rst_pin = lvl;
    repeat (3) @(posedge clk);
    // R1: outputs during reset
    chk("R1 locked in reset", mode_locked, 0);
    chk("R1 ready in reset", cmd_ready, 0);
    @(negedge clk);
    por_n = 1'b1;
  endtask

  // holds rst_pin low for k sampled edges, raises it; returns at negedge after selection edge
  task automatic cold_boot(input int k);
    power_up(1'b0);
    repeat (k) @(posedge clk);
    @(negedge clk);
    chk("R1 no mode while counting", mode_locked, 0);
    chk("R1 line idle while counting", io_pull_low, 0);
    rst_pin = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sync_warm();
    chk("R2 sync locked", mode_locked, 1);
    chk("R2 sync not async", mode_async, 0);
    for (int i = 1; i <= WARM; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R4 warm-up ready", cmd_ready, (i == WARM));
    end
  endtask

  // called at the negedge right after the selection edge
  task automatic check_atr(input logic [63:0] w, input int ncells);
    repeat (ETU/2) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < ncells; k++) begin
      chk("R6/R7/R8 cell", io_pull_low, exp_pull(w, k));
      if (k == 0 || k == ncells - 1) chk("R9 not ready during atr", cmd_ready, 0);
      if (k < ncells - 1) begin
        repeat (ETU) @(posedge clk);
        @(negedge clk);
      end
    end
    if (ncells == CELLS) begin
      repeat (ETU - ETU/2) @(posedge clk);
      @(negedge clk);
      chk("R9 ready after atr", cmd_ready, 1);
      chk("R8 released after atr", io_pull_low, 0);
    end
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5eed_0104);

    // R1 reset state right after release
    power_up(1'b1);
    chk("R1 locked before first edge", mode_locked, 0);
    chk("R1 pull before first edge", io_pull_low, 0);
    @(posedge clk);
    @(negedge clk);
    sync_warm();
    // R5: reset pin ignored in synchronous mode
    for (int i = 0; i < 20; i++) begin
      rst_pin = 1'($urandom_range(0, 1));
      @(posedge clk);
      @(negedge clk);
      chk("R5 sync mode kept", {mode_locked, mode_async}, 2'b10);
      chk("R5 sync ready kept", cmd_ready, 1);
      chk("R5 R8 sync line idle", io_pull_low, 0);
    end

    // R3 boundary: one short of the minimum
    cold_boot(COLD - 1);
    chk("R3 short cold gives sync", {mode_locked, mode_async}, 2'b10);
    sync_warm();

    // R3 boundary: exactly the minimum, full answer-to-reset
    atr_word = {$urandom, $urandom};
    cold_boot(COLD);
    chk("R3 cold gives async", {mode_locked, mode_async}, 2'b11);
    check_atr(atr_word, CELLS);

    // R10: abort mid-transmission, then restart
    atr_word = 64'hA5_00_FF_3C_81_7E_01_96;
    cold_boot(COLD + 50);
    check_atr(atr_word, 20);
    rst_pin = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 abort releases line", io_pull_low, 0);
    chk("R10 abort not ready", cmd_ready, 0);
    chk("R10 R5 mode kept", {mode_locked, mode_async}, 2'b11);
    repeat ($urandom_range(10, 50)) @(posedge clk);
    @(negedge clk);
    chk("R10 held line idle", io_pull_low, 0);
    rst_pin = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_atr(atr_word, CELLS);

    // R10: reset pin low after readiness
    rst_pin = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 ready cleared", cmd_ready, 0);
    chk("R10 R5 async kept", mode_async, 1);
    rst_pin = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_atr(atr_word, 12);

    // R3 random cold lengths around the threshold
    for (int i = 0; i < 6; i++) begin
      int k;
      k = 390 + int'($urandom_range(0, 20));
      atr_word = {$urandom, $urandom};
      cold_boot(k);
      chk("R3 random cold mode", mode_async, (k >= COLD));
      chk("R3 R7 start cell low", io_pull_low, (k >= COLD));
    end

    wrap_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

endmodule